// File: doc/BRIEF.md
# Fixed-Block CRC-16 Generator and Checker

This block protects a fixed-length data block of eighteen bytes with a sixteen-bit cyclic redundancy code. It serves both directions of a link. In transmit mode it takes the data bytes on a valid/ready input stream and folds each into a running CRC. When the last byte has been taken, it offers the inverted CRC on a separate valid/ready output stream, high byte first. In receive mode it takes the eighteen data bytes followed by the two received CRC bytes. It compares them against its own inverted result and reports the outcome as a one-cycle done strobe with an error flag beside it.

A controlling state machine has four states. IDLE waits for a start pulse. DATA accepts the data bytes. SEND offers the CRC bytes in transmit mode. CHECK accepts and compares the received CRC bytes in receive mode. The transitions are as follows. From any state, a start pulse moves to DATA and reloads the CRC register. DATA moves to SEND (transmit) or to CHECK (receive) when the eighteenth byte is accepted. SEND returns to IDLE when the low CRC byte is accepted. CHECK returns to IDLE when the second received byte is accepted. The register is reloaded on that return to IDLE.

Each data byte is consumed in one clock. Its eight bits enter the register least significant bit first.

Top module: `blkcrc_engine`

## Requirements
- R1: The CRC uses generator 0x1021 (x^16+x^12+x^5+1) on a non-reflected register preset to 0xFFFF. Each data byte is shifted in starting at its bit 0. The feedback bit is register bit 15 XOR the incoming data bit. The register shifts left and is XORed with 0x1021 when the feedback bit is 1.
- R2: After a start pulse, in_ready is high in state DATA and exactly 18 data bytes are accepted (in_valid and in_ready both high at a clock edge) before the block leaves DATA.
- R3: In transmit mode (mode_rx=0 at start) the block then asserts out_valid. It presents bits 15:8 of the inverted CRC on out_data, then bits 7:0, each accepted when out_valid and out_ready are both high.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R5: While the CRC bytes are being sent, in_ready is low and in_valid/in_data have no effect on the output bytes.
- R6: done is high for exactly one cycle: the cycle after the low CRC byte is accepted in transmit, or after the second received CRC byte is accepted in receive.
- R7: In receive mode the two bytes accepted after the data are compared, first with bits 15:8 and then with bits 7:0 of the inverted CRC. err is high together with done when either differs, and err is low otherwise.
- R8: A start pulse in any state abandons the current block, reloads 0xFFFF and begins a new block in DATA.
- R9: After reset, and in IDLE, in_ready, out_valid, done and err are all low, and in_valid is ignored.
- R10: mode_rx is sampled only at the start pulse. Changes during a block have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new block (pulse) |
| mode_rx | input | 1 | 1 = receive/check, 0 = transmit/generate; sampled at start |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte (data, or received CRC in receive mode) |
| in_ready | output | 1 | Block accepts an input byte |
| out_valid | output | 1 | CRC output byte valid |
| out_data | output | 8 | CRC output byte, high byte first |
| out_ready | input | 1 | Downstream accepts the CRC byte |
| done | output | 1 | One-cycle block completion strobe |
| err | output | 1 | CRC mismatch, valid with done |

## Verification
The assertions assume that start is a pulse that may arrive in any state. They also assume that a presented output byte is only withdrawn by a new start, never by the receiver. The stall-hold property is therefore excused in cycles where start is high. The stimulus raises start only between blocks, apart from one deliberate mid-block restart. The stimulus holds in_valid high with junk data while CRC bytes are being sent, and toggles mode_rx in the middle of a block. These cases stay within what the control logic must tolerate. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/blkcrc_pkg.sv
package blkcrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_SEND  = 2'd2,
        ST_CHECK = 2'd3
    } blkcrc_state_e;

endpackage

// File: rtl/blkcrc_datapath.sv
module blkcrc_datapath #(
    parameter int                CRC_W = 16,
    parameter logic [CRC_W-1:0]  POLY  = 16'h1021,
    parameter logic [CRC_W-1:0]  INIT  = 16'hFFFF,
    parameter int                IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crc_init,
    input  logic             crc_upd,
    input  logic [7:0]       in_data,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [7:0]       sel_byte,
    output logic             mismatch
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] crc_inv;

    // eight serial steps, bit 0 of the byte first
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_q;
        for (int k = 0; k < 8; k++) begin
            fb  = acc[CRC_W-1] ^ in_data[k];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_next = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (crc_init) begin
            crc_q <= INIT;
        end else if (crc_upd) begin
            crc_q <= crc_next;
        end
    end

    assign crc_inv  = ~crc_q;
    assign sel_byte = crc_inv[CRC_W-1-8*int'(sel_idx) -: 8];
    assign mismatch = (in_data != sel_byte);

    // R8: every reload request leaves the preset value in the register
    assert_reload_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_init |=> (crc_q == INIT));

    // R5: register frozen while nothing is being folded in or reloaded
    assert_crc_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!crc_init && !crc_upd) |=> $stable(crc_q));

endmodule

// File: rtl/blkcrc_ctrl.sv
module blkcrc_ctrl
    import blkcrc_pkg::*;
#(
    parameter int DATA_BYTES = 18,
    parameter int OUT_BYTES  = 2,
    parameter int IDX_W      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_rx,
    input  logic             in_valid,
    input  logic             out_ready,
    input  logic             mismatch,
    output logic             in_ready,
    output logic             out_valid,
    output logic             crc_init,
    output logic             crc_upd,
    output logic [IDX_W-1:0] sel_idx,
    output logic             done,
    output logic             err
);

    localparam int               CNT_W    = $clog2(DATA_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(OUT_BYTES - 1);

    blkcrc_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             rx_q;
    logic             mis_q;
    logic             done_q, err_q;

    logic acc_in, acc_out, data_last, crc_last, block_end;

    assign acc_in    = in_valid && in_ready;
    assign acc_out   = out_valid && out_ready;
    assign data_last = (cnt_q == CNT_LAST);
    assign crc_last  = (idx_q == IDX_LAST);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_IDLE;
            ST_DATA:  if (acc_in && data_last) state_d = rx_q ? ST_CHECK : ST_SEND;
            ST_SEND:  if (acc_out && crc_last) state_d = ST_IDLE;
            ST_CHECK: if (acc_in && crc_last)  state_d = ST_IDLE;
        endcase
        if (start) state_d = ST_DATA;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        block_end = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DATA:  in_ready = 1'b1;
            ST_SEND: begin
                out_valid = 1'b1;
                block_end = acc_out && crc_last;
            end
            ST_CHECK: begin
                in_ready  = 1'b1;
                block_end = acc_in && crc_last;
            end
        endcase
        crc_init = start || block_end;
        crc_upd  = (state_q == ST_DATA) && acc_in && !start;
    end

    // counters, mode latch, sticky compare and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            rx_q   <= 1'b0;
            mis_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= block_end && !start;
            err_q  <= block_end && !start && (state_q == ST_CHECK) && (mis_q || mismatch);
            if (start) begin
                cnt_q <= '0;
                idx_q <= '0;
                rx_q  <= mode_rx;
                mis_q <= 1'b0;
            end else begin
                if ((state_q == ST_DATA) && acc_in)
                    cnt_q <= data_last ? '0 : cnt_q + 1'b1;
                if (((state_q == ST_SEND) && acc_out) || ((state_q == ST_CHECK) && acc_in))
                    idx_q <= crc_last ? '0 : idx_q + 1'b1;
                if ((state_q == ST_CHECK) && acc_in)
                    mis_q <= mis_q || mismatch;
            end
        end
    end

    assign sel_idx = idx_q;
    assign done    = done_q;
    assign err     = err_q;

    // R6: completion strobe never lasts two cycles
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: an error report only ever accompanies completion
    assert_err_has_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R5: the input and output streams are never open together
    assert_streams_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R2: data byte count stays inside the block
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(DATA_BYTES));

    // R10: latched direction changes only at a start pulse
    assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(rx_q));

endmodule

// File: rtl/blkcrc_engine.sv
module blkcrc_engine #(
    parameter int               DATA_BYTES = 18,
    parameter int               CRC_W      = 16,
    parameter logic [CRC_W-1:0] POLY       = 16'h1021,
    parameter logic [CRC_W-1:0] INIT       = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mode_rx,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready,
    output logic       done,
    output logic       err
);

    localparam int OUT_BYTES = CRC_W / 8;
    localparam int IDX_W     = (OUT_BYTES > 1) ? $clog2(OUT_BYTES) : 1;

    logic             crc_init, crc_upd, mismatch;
    logic [IDX_W-1:0] sel_idx;
    logic [7:0]       sel_byte;

    blkcrc_ctrl #(
        .DATA_BYTES (DATA_BYTES),
        .OUT_BYTES  (OUT_BYTES),
        .IDX_W      (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_rx   (mode_rx),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .mismatch  (mismatch),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .crc_init  (crc_init),
        .crc_upd   (crc_upd),
        .sel_idx   (sel_idx),
        .done      (done),
        .err       (err)
    );

    blkcrc_datapath #(
        .CRC_W (CRC_W),
        .POLY  (POLY),
        .INIT  (INIT),
        .IDX_W (IDX_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .crc_init (crc_init),
        .crc_upd  (crc_upd),
        .in_data  (in_data),
        .sel_idx  (sel_idx),
        .sel_byte (sel_byte),
        .mismatch (mismatch)
    );

    assign out_data = sel_byte;

    // R4: a stalled output byte is held until taken
    assert_hold_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/blkcrc_engine_bench.sv
module blkcrc_engine_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, mode_rx = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, done, err;
    logic [7:0] out_data;

    int checks = 0, fails = 0, cyc = 0;
    bit compare_on = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    blkcrc_engine u_blkcrc_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_rx(mode_rx),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .done(done), .err(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic f = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (f) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_ph = 0;      // 0 idle, 1 data, 2 send, 3 check
    int          m_cnt = 0, m_idx = 0;
    logic [15:0] m_crc = 16'hFFFF;
    bit          m_rx = 0, m_mis = 0, m_done = 0, m_err = 0;

    function automatic logic [7:0] m_byte(input logic [15:0] c, input int idx);
        logic [15:0] v = ~c;
        return (idx == 0) ? v[15:8] : v[7:0];
    endfunction

    always @(posedge clk) begin
        m_done = 0; m_err = 0;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_idx = 0; m_crc = 16'hFFFF; m_rx = 0; m_mis = 0;
        end else if (start) begin
            m_ph = 1; m_cnt = 0; m_idx = 0; m_crc = 16'hFFFF; m_rx = mode_rx; m_mis = 0;
        end else begin
            case (m_ph)
                1: if (in_valid) begin
                    m_crc = fold(m_crc, in_data);
                    m_cnt++;
                    if (m_cnt == 18) begin m_cnt = 0; m_ph = m_rx ? 3 : 2; end
                end
                2: if (out_ready) begin
                    if (m_idx == 1) begin m_ph = 0; m_idx = 0; m_done = 1; m_crc = 16'hFFFF; end
                    else m_idx++;
                end
                3: if (in_valid) begin
                    if (in_data != m_byte(m_crc, m_idx)) m_mis = 1;
                    if (m_idx == 1) begin
                        m_ph = 0; m_idx = 0; m_done = 1; m_err = m_mis; m_crc = 16'hFFFF;
                    end else m_idx++;
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check("R2 in_ready", int'(in_ready), int'(m_ph == 1 || m_ph == 3));
            check("R3 out_valid", int'(out_valid), int'(m_ph == 2));
            if (m_ph == 2) check("R4 out_data", int'(out_data), int'(m_byte(m_crc, m_idx)));
            check("R6 done", int'(done), int'(m_done));
            check("R7 err", int'(err), int'(m_err));
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] blk [18];
    logic [15:0] exp_crc;

    task automatic fill(input int seed);
        for (int i = 0; i < 18; i++) begin
            if (seed == -1)      blk[i] = 8'h00;
            else if (seed == -2) blk[i] = 8'hFF;
            else                 blk[i] = 8'((seed * 37 + i * 91 + i * i * 13) & 255);
        end
        exp_crc = 16'hFFFF;
        for (int i = 0; i < 18; i++) exp_crc = fold(exp_crc, blk[i]);
        exp_crc = ~exp_crc;
    endtask

    task automatic pulse_start(input bit rx);
        @(negedge clk);
        start = 1'b1; mode_rx = rx;
        @(negedge clk);
        start = 1'b0;
    endtask

    // feed n data bytes (n<=18), with gaps every 'gap' cycles when gap>0
    task automatic feed(input int n, input int gap, input bit flip_mode);
        int i = 0, k = 0;
        while (i < n) begin
            in_valid = (gap == 0) || ((k % gap) != 0);
            in_data  = blk[i];
            if (flip_mode && i == 9) mode_rx = ~mode_rx;  // R10 stimulus
            k++;
            if (in_valid && in_ready) i++;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic tx_block(input int seed, input int gap, input int stall, input bit flip_mode);
        logic [7:0] got [2];
        int j = 0, k = 0;
        fill(seed);
        pulse_start(1'b0);
        feed(18, gap, flip_mode);
        while (j < 2) begin
            out_ready = (stall == 0) || ((k % stall) == 0);
            in_valid  = 1'b1; in_data = 8'hA5;   // junk while sending
            check("R5 in_ready low while sending", int'(in_ready), 0);
            k++;
            if (out_valid && out_ready) begin got[j] = out_data; j++; end
            @(negedge clk);
        end
        out_ready = 1'b0; in_valid = 1'b0;
        check("R6 done after low byte (tx)", int'(done), 1);
        check("R1 R3 high CRC byte", int'(got[0]), int'(exp_crc[15:8]));
        check("R1 R3 low CRC byte", int'(got[1]), int'(exp_crc[7:0]));
        @(negedge clk);
        check("R6 done single cycle", int'(done), 0);
    endtask

    task automatic rx_block(input int seed, input int gap, input logic [15:0] flip);
        logic [15:0] sent;
        fill(seed);
        sent = exp_crc ^ flip;
        pulse_start(1'b1);
        feed(18, gap, 1'b0);
        blk[0] = sent[15:8]; blk[1] = sent[7:0];
        feed(2, gap, 1'b0);
        check("R6 done after second rx byte", int'(done), 1);
        check("R7 err on compare", int'(err), int'(flip != 16'h0));
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset in_ready", int'(in_ready), 0);
        check("R9 reset out_valid", int'(out_valid), 0);
        check("R9 reset done", int'(done), 0);
        check("R9 reset err", int'(err), 0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h3C;        // ignored in IDLE (R9)
        repeat (3) @(negedge clk);
        check("R9 idle in_ready", int'(in_ready), 0);
        in_valid = 1'b0;

        tx_block(1, 0, 0, 1'b0);
        tx_block(2, 3, 3, 1'b0);                  // R4 stalls
        tx_block(-1, 0, 2, 1'b0);
        tx_block(-2, 4, 0, 1'b0);
        tx_block(5, 2, 0, 1'b1);                  // R10 mode toggled mid-block

        rx_block(7, 0, 16'h0000);
        rx_block(8, 3, 16'h0100);                 // R7 high byte corrupt
        rx_block(9, 0, 16'h0001);                 // R7 low byte corrupt
        rx_block(-2, 2, 16'h0000);

        // R8: abandon a partial block, restart with fresh data
        fill(11);
        pulse_start(1'b1);
        feed(7, 0, 1'b0);
        tx_block(12, 0, 0, 1'b0);
        check("R8 restart leaves no error", int'(err), 0);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule